// File: doc/BRIEF.md
# Sector Hamming Code Generator

This block is a parity engine that sits beside the data port of a NAND flash controller. It watches every byte that crosses the port and builds a line/column Hamming code over a 512-byte sector. The sector is split into a lower and an upper half of 256 bytes. Each half gets its own three-byte code, so a sector carries six code bytes. Each half-code can locate one flipped bit, so a sector can be repaired for up to two bit errors in total. The repair itself is done in software.

Software steers the block by writing 8-bit values to a mode register. One value arms a clear, and the data-port read that follows performs it. Another value makes the engine fold each following data byte into the running parities. A third value turns host reads of the data port into a readout of the six code bytes, packed two to a 16-bit word in an interleaved order. Any other value, including the normal data value, leaves the engine dormant.

`dat_vld` marks one byte crossing the port in either direction. `rd_req` marks one 16-bit host read of the data port.

Top module: `ecc_sector_gen`

## Requirements
- R1: After reset, `ecc_vld` is 0, `ecc_word` is 16'hFFFF, and a readout returns 16'hFFFF for all three words, because the empty code is stored inverted.
- R2: Mode values are decoded as follows: 8'hF4 arms a clear, 8'hB4 accumulates, 8'hD4 reads out, and any other value (8'h94 included) is dormant. In a dormant mode, bytes are not folded in and reads produce no `ecc_vld`.
- R3: The clear (both half-codes, the byte counter and the readout position) happens only on an `rd_req` while the armed-clear mode is in force. If 8'hB4 follows 8'hF4 with no read in between, the old state is kept.
- R4: A byte is folded in only when `dat_vld` is 1 while the accumulate mode is in force.
- R5: Line parity: for each bit k (0..7) of the byte's index within its half, code bit 2k is the XOR of the parity of all bytes whose index bit k is 0, and bit 2k+1 is the same for index bit k equal to 1. Bits 0..7 form code byte 0 and bits 8..15 form code byte 1 of that half.
- R6: Column parity: code byte 2 of a half holds, from bit 7 down to bit 2, the XOR over all of its bytes of data bits {7:4}, {3:0}, {7,6,3,2}, {5,4,1,0}, {7,5,3,1} and {6,4,2,0}. Bits 1:0 are 1. All three code bytes are stored inverted.
- R7: Accepted bytes 0..255 feed the lower half-code (code bytes 0..2), and accepted bytes 256..511 feed the upper half-code (code bytes 3..5).
- R8: After 512 accepted bytes, further bytes are ignored until the next clear.
- R9: In readout, the first read returns {byte0, byte1}, the second returns {byte4, byte2} and the third returns {byte5, byte3}, given as {high, low}.
- R10: A fourth or later read returns 16'hFFFF, and the stored codes are not disturbed. Writing 8'hD4 again restarts the readout at the first word with the same values.
- R11: `ecc_vld` is 1 for exactly the cycle after each `rd_req` accepted in readout mode, with `ecc_word` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_val | input | 8 | Mode value written |
| dat_vld | input | 1 | One byte crosses the data port |
| dat_byte | input | 8 | That byte |
| rd_req | input | 1 | One 16-bit host read of the data port |
| ecc_vld | output | 1 | Readout word valid |
| ecc_word | output | 16 | Readout word |

## Verification
The engine is fed three kinds of sector. The first is a full 512-byte pseudo-random sector, where every line and column bit of both halves is exercised at once. The second is an all-zero sector with a single set bit at byte 300, which pins down the half switch and shows whether the line-parity bits follow the index bits. The third is a short 10-byte run, which separates the lower half from an untouched upper half that must still read all-ones. Between these, bytes are sent after the sector is full, in the normal-data mode and in an unrelated mode, and a clear is attempted without its dummy read. The rereads that follow each of these must return unchanged words.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int BYTE_W       = 8;
  localparam int IDX_W        = 8;
  localparam int HALF_BYTES   = 1 << IDX_W;
  localparam int SECTOR_BYTES = 2 * HALF_BYTES;
  localparam int LP_W         = 2 * IDX_W;
  localparam int CODE_W       = 24;
  localparam int WORD_W       = 16;

  localparam logic [7:0] MODE_CLEAR = 8'hF4;
  localparam logic [7:0] MODE_CALC  = 8'hB4;
  localparam logic [7:0] MODE_OUT   = 8'hD4;

  typedef enum logic [1:0] {EM_IDLE, EM_CLEAR, EM_CALC, EM_OUT} ecc_mode_e;

  // fold one byte's parity into the even/odd line-parity pairs
  function automatic logic [LP_W-1:0] lp_next(input logic [LP_W-1:0] lp,
                                              input logic [IDX_W-1:0] idx,
                                              input logic [BYTE_W-1:0] d);
    logic [LP_W-1:0] r;
    r = lp;
    if (^d) begin
      for (int k = 0; k < IDX_W; k++) begin
        r[2*k + int'(idx[k])] = ~r[2*k + int'(idx[k])];
      end
    end
    return r;
  endfunction

  // six column parities from the XOR of all bytes, bit5 down to bit0
  function automatic logic [5:0] col_code(input logic [BYTE_W-1:0] c);
    return {^c[7:4], ^c[3:0], ^{c[7:6], c[3:2]}, ^{c[5:4], c[1:0]},
            ^{c[7], c[5], c[3], c[1]}, ^{c[6], c[4], c[2], c[0]}};
  endfunction

  // {byte2, byte1, byte0}, inverted, spare bits end up as ones
  function automatic logic [CODE_W-1:0] pack_code(input logic [LP_W-1:0] lp,
                                                  input logic [BYTE_W-1:0] col);
    return ~{col_code(col), 2'b00, lp[15:8], lp[7:0]};
  endfunction

  // interleaved readout of the six bytes
  function automatic logic [WORD_W-1:0] ro_word(input logic [CODE_W-1:0] c0,
                                                input logic [CODE_W-1:0] c1,
                                                input logic [1:0] k);
    case (k)
      2'd0:    return {c0[7:0],   c0[15:8]};
      2'd1:    return {c1[15:8],  c0[23:16]};
      2'd2:    return {c1[23:16], c1[7:0]};
      default: return 16'hFFFF;
    endcase
  endfunction
endpackage

// File: rtl/ecc_mode_ctl.sv
module ecc_mode_ctl
  import ecc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic [7:0] mode_val,
  input  logic       rd_req,
  output logic       acc_mode,
  output logic       out_mode,
  output logic       clr_evt,
  output logic       ro_restart
);
  ecc_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= EM_IDLE;
    end else if (mode_we) begin
      case (mode_val)
        MODE_CLEAR: mode_q <= EM_CLEAR;
        MODE_CALC:  mode_q <= EM_CALC;
        MODE_OUT:   mode_q <= EM_OUT;
        default:    mode_q <= EM_IDLE;
      endcase
    end
  end

  assign acc_mode   = (mode_q == EM_CALC);
  assign out_mode   = (mode_q == EM_OUT);
  assign clr_evt    = rd_req && (mode_q == EM_CLEAR);
  assign ro_restart = mode_we && (mode_val == MODE_OUT);

  AST_CALC_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && mode_val == MODE_CALC) |=> acc_mode); // R2
  AST_OTHER_DORMANT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && mode_val == 8'h94) |=> (!acc_mode && !out_mode)); // R2
endmodule

// File: rtl/ecc_byte_cnt.sv
module ecc_byte_cnt #(
  parameter int TOTAL = 512,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step_req,
  output logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             half_sel,
  output logic             full
);
  localparam int CNT_W = $clog2(TOTAL) + 1;

  logic [CNT_W-1:0] cnt_q;

  assign full     = (cnt_q == CNT_W'(TOTAL));
  assign step     = step_req && !full;
  assign idx      = cnt_q[IDX_W-1:0];
  assign half_sel = cnt_q[IDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (step)     cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(TOTAL)); // R8
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R3
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/ecc_half_acc.sv
module ecc_half_acc
  import ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] d,
  output logic [CODE_W-1:0] code
);
  logic [LP_W-1:0]   lp_q;
  logic [BYTE_W-1:0] col_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      lp_q  <= '0;
      col_q <= '0;
    end else if (en) begin
      lp_q  <= lp_next(lp_q, idx, d);
      col_q <= col_q ^ d;
    end
  end

  assign code = pack_code(lp_q, col_q);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> ($stable(lp_q) && $stable(col_q))); // R4
endmodule

// File: rtl/ecc_readout.sv
module ecc_readout
  import ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              restart,
  input  logic              out_mode,
  input  logic              rd_req,
  input  logic [CODE_W-1:0] code0,
  input  logic [CODE_W-1:0] code1,
  output logic              ecc_vld,
  output logic [WORD_W-1:0] ecc_word
);
  logic [1:0] idx_q;
  logic       rd_fire;

  assign rd_fire = rd_req && out_mode;

  always_ff @(posedge clk) begin
    if (!rst_n || clr || restart) idx_q <= '0;
    else if (rd_fire && idx_q != 2'd3) idx_q <= idx_q + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ecc_vld  <= 1'b0;
      ecc_word <= '1;
    end else begin
      ecc_vld <= rd_fire;
      if (rd_fire) ecc_word <= ro_word(code0, code1, idx_q);
    end
  end

  AST_VLD_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_vld |-> $past(rd_req)); // R11
  AST_PAST_END_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && idx_q == 2'd3) |=> (ecc_word == 16'hFFFF)); // R10
endmodule

// File: rtl/ecc_sector_gen.sv
module ecc_sector_gen
  import ecc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_we,
  input  logic [7:0]  mode_val,
  input  logic        dat_vld,
  input  logic [7:0]  dat_byte,
  input  logic        rd_req,
  output logic        ecc_vld,
  output logic [15:0] ecc_word
);
  localparam int HALVES = 2;

  logic acc_mode, out_mode, clr_evt, ro_restart;
  logic step, half_sel, full;
  logic [IDX_W-1:0] idx;
  logic [HALVES-1:0] en_vec;
  logic [HALVES-1:0][CODE_W-1:0] codes;

  ecc_mode_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_val(mode_val),
    .rd_req(rd_req), .acc_mode(acc_mode), .out_mode(out_mode),
    .clr_evt(clr_evt), .ro_restart(ro_restart)
  );

  ecc_byte_cnt #(.TOTAL(SECTOR_BYTES), .IDX_W(IDX_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr_evt), .step_req(dat_vld && acc_mode),
    .step(step), .idx(idx), .half_sel(half_sel), .full(full)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign en_vec[h] = step && (half_sel == 1'(h));
    ecc_half_acc u_acc (
      .clk(clk), .rst_n(rst_n), .clr(clr_evt), .en(en_vec[h]),
      .idx(idx), .d(dat_byte), .code(codes[h])
    );
  end

  ecc_readout u_ro (
    .clk(clk), .rst_n(rst_n), .clr(clr_evt), .restart(ro_restart),
    .out_mode(out_mode), .rd_req(rd_req), .code0(codes[0]), .code1(codes[1]),
    .ecc_vld(ecc_vld), .ecc_word(ecc_word)
  );

  AST_ONE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en_vec)); // R7
  AST_FULL_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (en_vec == '0)); // R8
endmodule

// File: tb/sim_ecc_sector_gen.sv
module sim_ecc_sector_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_we = 1'b0;
  logic [7:0] mode_val = 8'h00;
  logic dat_vld = 1'b0;
  logic [7:0] dat_byte = 8'h00;
  logic rd_req = 1'b0;
  logic ecc_vld;
  logic [15:0] ecc_word;

  always #10 clk = ~clk;

  ecc_sector_gen u0 (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_val(mode_val),
    .dat_vld(dat_vld), .dat_byte(dat_byte), .rd_req(rd_req),
    .ecc_vld(ecc_vld), .ecc_word(ecc_word)
  );

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  // reference state kept from the requirements
  logic [7:0] img [0:511];
  int n_acc = 0;
  int mmode = 0;  // 0 dormant, 1 clear armed, 2 accumulate, 3 readout
  int ro_k = 0;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] cbyte(input int h, input int b);
    logic [7:0] r;
    logic [7:0] x;
    r = '0;
    if (b < 2) begin
      for (int q = 0; q < 8; q++) begin
        int m = b*8 + q;
        bit acc = 0;
        for (int j = 0; j < 256; j++)
          if (((j >> (m/2)) & 1) == (m % 2)) acc ^= ^img[h*256 + j];
        r[q] = ~acc;
      end
    end else begin
      x = '0;
      for (int j = 0; j < 256; j++) x ^= img[h*256 + j];
      r = ~{^(x & 8'hF0), ^(x & 8'h0F), ^(x & 8'hCC), ^(x & 8'h33),
            ^(x & 8'hAA), ^(x & 8'h55), 2'b00};
    end
    return r;
  endfunction

  function automatic logic [15:0] exp_word(input int k);
    case (k)
      0: return {cbyte(0, 0), cbyte(0, 1)};
      1: return {cbyte(1, 1), cbyte(0, 2)};
      2: return {cbyte(1, 2), cbyte(1, 0)};
      default: return 16'hFFFF;
    endcase
  endfunction

  task automatic set_mode(input logic [7:0] v);
    @(negedge clk);
    dat_vld = 1'b0; mode_we = 1'b1; mode_val = v;
    case (v)
      8'hF4: mmode = 1;
      8'hB4: mmode = 2;
      8'hD4: begin mmode = 3; ro_k = 0; end
      default: mmode = 0;
    endcase
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    dat_vld = 1'b1; dat_byte = b;
    if (mmode == 2 && n_acc < 512) begin
      img[n_acc] = b;
      n_acc++;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    dat_vld = 1'b0; rd_req = 1'b0; mode_we = 1'b0;
  endtask

  task automatic rd(input string tag);
    @(negedge clk);
    dat_vld = 1'b0; rd_req = 1'b1;
    if (mmode == 3) begin
      exp_q.push_back(exp_word(ro_k));
      tag_q.push_back(tag);
      if (ro_k < 3) ro_k++;
    end else if (mmode == 1) begin
      for (int j = 0; j < 512; j++) img[j] = 8'h00;
      n_acc = 0;
      ro_k = 0;
    end
    @(negedge clk);
    rd_req = 1'b0;
    if (mmode != 3) chk(ecc_vld == 1'b0, {tag, " no readout valid"}, 16'(ecc_vld), 16'h0);
  endtask

  task automatic read_all(input string tag);
    set_mode(8'hD4);
    for (int k = 0; k < 4; k++) rd(tag);
  endtask

  task automatic fresh();
    set_mode(8'hF4);
    rd("R3 dummy");
    set_mode(8'hB4);
  endtask

  // monitor: compares each readout word against the scoreboard
  always @(negedge clk) begin
    if (rst_n && ecc_vld) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected valid", ecc_word, 16'h0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(ecc_word == e, t, ecc_word, e);
      end
    end
  end

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R11 watchdog expired", 16'h0, 16'h1);
    report();
  end

  initial begin
    for (int j = 0; j < 512; j++) img[j] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ecc_vld == 1'b0, "R1 reset valid", 16'(ecc_vld), 16'h0);
    chk(ecc_word == 16'hFFFF, "R1 reset word", ecc_word, 16'hFFFF);
    read_all("R1 R9 empty codes");

    // full pseudo-random sector
    fresh();
    for (int j = 0; j < 512; j++) push(8'((j * 37 + 11) ^ (j >> 3)));
    idle();
    read_all("R5 R6 R7 R9 R10 random sector");
    read_all("R10 reread");

    // bytes after the sector is full
    set_mode(8'hB4);
    for (int j = 0; j < 20; j++) push(8'(j + 1));
    idle();
    read_all("R8 overflow ignored");

    // clear armed, but no dummy read before accumulate
    set_mode(8'hF4);
    set_mode(8'hB4);
    push(8'h5A);
    idle();
    read_all("R3 no clear without read");

    // single set bit in upper half
    fresh();
    for (int j = 0; j < 512; j++) push((j == 300) ? 8'h10 : 8'h00);
    idle();
    read_all("R7 R5 single bit byte 300");

    // short run, upper half untouched
    fresh();
    for (int j = 0; j < 10; j++) push(8'(8'hC3 ^ (j * 29)));
    idle();
    read_all("R7 short run");

    // dormant modes
    fresh();
    for (int j = 0; j < 5; j++) push(8'(j * 51 + 7));
    set_mode(8'h94);
    for (int j = 0; j < 6; j++) push(8'hFF - 8'(j));
    idle();
    rd("R4 read in normal mode");
    set_mode(8'h0C);
    for (int j = 0; j < 6; j++) push(8'h81);
    idle();
    rd("R2 read in other mode");
    set_mode(8'hB4);
    for (int j = 0; j < 7; j++) push(8'(j * 13 + 200));
    idle();
    read_all("R2 R4 dormant bytes skipped");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all readouts seen", 16'(exp_q.size()), 16'h0);
    report();
  end
endmodule